// File: doc/BRIEF.md
# Compare/Overflow General-Purpose Timer

This block is a register-mapped up-counter for system timekeeping and timeouts. While it is running, a counter of CNT_W bits (32 by default) advances by one each clock. Software can read the live count at any time and can also write it directly. When the counter wraps past its all-ones value, it restarts from a programmable load value and raises an overflow event. A compare stage raises a match event when an increment lands the counter on the programmed match value. The counter keeps running after a match.

A capture pin is synchronised to the clock. Each rising edge on it stores a snapshot of the counter and raises a capture event. All three events are held in a sticky status register. A status bit is cleared only by writing a one to it. The single interrupt output is the OR of the status bits that have their enable bit set. Software usually reads the status register, handles what it finds, and writes the same value back to acknowledge exactly those events.

The register bus is word addressed. Writes take effect at the clock edge where the write strobe is sampled. Reads are combinational from the current register state.

Top module: `gp_timer`

## Requirements
- R1: After reset, status, interrupt enable, control, counter, load, match and capture all read 0, and irq is 0.
- R2: Offset 0 reads the revision byte, with the major revision in bits [7:4] and the minor revision in bits [3:0] (0x10 with default parameters). Writes to offset 0 are ignored. Unmapped offsets (for example 3) read 0.
- R3: When control bit 0 (offset 8) is set, the counter (offset 9) increases by 1 per clock and reads back live. When that bit is clear, the counter holds its value. A write to offset 9 loads the counter, and this write takes priority over the increment.
- R4: An increment from the all-ones value loads the counter from the load register (offset 10) and sets status bit 1 (overflow) in the same cycle.
- R5: When control bits 0 and 6 are both set, an increment that makes the counter equal to the match register (offset 13) sets status bit 0 (match) in the same cycle. No match is raised in these cases: bit 6 is clear, the counter is frozen, the counter is loaded by a write, or the counter merely sits at the match value.
- R6: A rising edge on cap_in, after a two-stage synchroniser, copies the counter into the capture register (offset 14) and sets status bit 2. Holding cap_in high causes no further capture.
- R7: Writing the status register (offset 6) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: An event that arrives in the same cycle as a write clearing its status bit leaves that bit set.
- R9: irq is 1 exactly when some status bit is set and its bit in the interrupt enable register (offset 7, same bit positions as status) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Word offset of the register access |
| reg_we | input | 1 | Write strobe, sampled at the rising clock edge |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr, combinational |
| cap_in | input | 1 | Asynchronous capture request, rising edge active |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions check the cycle-level rules on every cycle. A running counter steps by one. A frozen counter holds its value. A wrap reloads from the load register. A match leaves the counter at the match value. A capture stores the previous count and lasts one cycle. Status bits stay set once an event arrives, and they follow the write-one-to-clear rule. Only the bench scenarios can show the behaviour seen from software. Those scenarios cover exact counts read across start and stop, a wrap to a non-zero load value, a match that does not fire on an equal but untouched count, a clear that collides with a match, capture synchronisation and edge detection, and interrupt gating by the enable bits.

// File: rtl/gpt_pkg.sv
// Package: register offsets, status bit positions and control bit positions
// shared by the timer modules. Offsets are word addresses on a 4-bit bus.
package gpt_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_ID    = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_CNT   = 4'd9;
    localparam logic [ADDR_W-1:0] OFS_LOAD  = 4'd10;
    localparam logic [ADDR_W-1:0] OFS_MATCH = 4'd13;
    localparam logic [ADDR_W-1:0] OFS_CAP   = 4'd14;

    localparam int N_EV     = 3;
    localparam int EV_MATCH = 0;
    localparam int EV_OVF   = 1;
    localparam int EV_CAP   = 2;

    localparam int CTRL_RUN = 0;
    localparam int CTRL_MEN = 6;

    typedef logic [N_EV-1:0] ev_t;
endpackage

// File: rtl/gpt_counter.sv
// Module: gpt_counter
// Free-running up-counter with software load, wrap-to-load on overflow and
// an increment-time compare against a match value.
// Assumes: cnt_we and run are synchronous to clk; a write beats an increment
// and raises no event.
module gpt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         men,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] match_val,
    output logic [W-1:0] cnt_o,
    output logic         ovf_evt,
    output logic         match_evt
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;
    logic         at_top;

    assign at_top  = &cnt_q;
    assign cnt_inc = at_top ? load_val : cnt_q + W'(1);

    // Counter register: software load first, then increment when running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= cnt_wdata;
        end else if (run) begin
            cnt_q <= cnt_inc;
        end
    end

    assign ovf_evt   = run && !cnt_we && at_top;
    assign match_evt = run && men && !cnt_we && (cnt_inc == match_val);
    assign cnt_o     = cnt_q;

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we) |=> $stable(cnt_q));
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_we && !at_top) |=> (cnt_q == $past(cnt_q) + W'(1)));
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (cnt_q == $past(load_val)));
    assert_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> (cnt_q == $past(match_val)));
endmodule

// File: rtl/gpt_capture.sv
// Module: gpt_capture
// Synchronises the asynchronous capture pin, detects its rising edge and
// stores a counter snapshot on each edge.
// Assumes: SYNC >= 2; cap_in may change at any time.
module gpt_capture #(
    parameter int W    = 32,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_in,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cap_val,
    output logic         cap_evt
);
    logic [SYNC-1:0] sync_q;
    logic            prev_q;
    logic [W-1:0]    cap_q;

    // Synchroniser chain and delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], cap_in};
            prev_q <= sync_q[SYNC-1];
        end
    end

    assign cap_evt = sync_q[SYNC-1] && !prev_q;

    // Snapshot register, written only on a detected rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (cap_evt) begin
            cap_q <= cnt;
        end
    end

    assign cap_val = cap_q;

    assert_snap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_val == $past(cnt)));
    assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> !cap_evt);
endmodule

// File: rtl/gpt_status.sv
// Module: gpt_status
// Sticky event flags with write-one-to-clear and an enable-gated interrupt.
// Assumes: evt bits are single-cycle or level events; an event wins over a
// clear of the same bit in the same cycle.
module gpt_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] ien,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] st_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // One flag: set by its event, cleared by a one written to its bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[i] <= 1'b0;
            end else if (evt[i]) begin
                st_q[i] <= 1'b1;
            end else if (clr_we && clr_mask[i]) begin
                st_q[i] <= 1'b0;
            end
        end
    end

    assign status = st_q;
    assign irq    = |(st_q & ien);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt)));
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && evt == '0) |=> (status == ($past(status) & ~$past(clr_mask))));
    assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && evt == '0) |=> $stable(status));
endmodule

// File: rtl/gp_timer.sv
// Module: gp_timer (top)
// Register-mapped timer: holds the control, enable, load and match registers,
// decodes bus writes, muxes reads and connects counter, capture and status.
// Assumes: one register access per cycle; reads are combinational.
module gp_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int REV_MAJOR   = 1,
    parameter int REV_MINOR   = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              cap_in,
    output logic              irq
);
    localparam logic [7:0] REV_BYTE = 8'(((REV_MAJOR % 16) * 16) + (REV_MINOR % 16));

    logic             run_q, men_q;
    ev_t              ien_q;
    logic [CNT_W-1:0] load_q, match_q;
    logic [CNT_W-1:0] cnt, cap_val;
    logic             ovf_evt, match_evt, cap_evt;
    ev_t              evt, status;
    logic             wr_stat, wr_cnt;

    assign wr_stat = reg_we && (reg_addr == OFS_STAT);
    assign wr_cnt  = reg_we && (reg_addr == OFS_CNT);

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            men_q   <= 1'b0;
            ien_q   <= '0;
            load_q  <= '0;
            match_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_CTRL: begin
                    run_q <= reg_wdata[CTRL_RUN];
                    men_q <= reg_wdata[CTRL_MEN];
                end
                OFS_IEN:   ien_q   <= reg_wdata[N_EV-1:0];
                OFS_LOAD:  load_q  <= reg_wdata;
                OFS_MATCH: match_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    gpt_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .men       (men_q),
        .cnt_we    (wr_cnt),
        .cnt_wdata (reg_wdata),
        .load_val  (load_q),
        .match_val (match_q),
        .cnt_o     (cnt),
        .ovf_evt   (ovf_evt),
        .match_evt (match_evt)
    );

    gpt_capture #(.W(CNT_W), .SYNC(SYNC_STAGES)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_in  (cap_in),
        .cnt     (cnt),
        .cap_val (cap_val),
        .cap_evt (cap_evt)
    );

    // Event vector in status bit order.
    always_comb begin
        evt           = '0;
        evt[EV_MATCH] = match_evt;
        evt[EV_OVF]   = ovf_evt;
        evt[EV_CAP]   = cap_evt;
    end

    gpt_status #(.N(N_EV)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr_we   (wr_stat),
        .clr_mask (reg_wdata[N_EV-1:0]),
        .ien      (ien_q),
        .status   (status),
        .irq      (irq)
    );

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_ID:    reg_rdata[7:0]      = REV_BYTE;
            OFS_STAT:  reg_rdata[N_EV-1:0] = status;
            OFS_IEN:   reg_rdata[N_EV-1:0] = ien_q;
            OFS_CTRL: begin
                reg_rdata[CTRL_RUN] = run_q;
                reg_rdata[CTRL_MEN] = men_q;
            end
            OFS_CNT:   reg_rdata = cnt;
            OFS_LOAD:  reg_rdata = load_q;
            OFS_MATCH: reg_rdata = match_q;
            OFS_CAP:   reg_rdata = cap_val;
            default: ;
        endcase
    end

    assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));
endmodule

// File: tb/tb_gp_timer.sv
module tb_gp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cap_in = 1'b0;
    logic        irq;

    gp_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in), .irq(irq)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [31:0] d;
        logic        i;
        string       tag;
    } item_t;

    item_t q[$];
    logic  sample_req = 1'b0;
    int    checks = 0;
    int    failures = 0;
    bit    done = 0;

    // Monitor: pop one expected item per requested sample, mid-cycle.
    always @(negedge clk) begin
        if (sample_req) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (reg_rdata !== it.d || irq !== it.i) begin
                failures++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         it.tag, reg_rdata, irq, it.d, it.i);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] d, input logic i, input string tag);
        item_t it;
        @(posedge clk); #1;
        reg_addr = a;
        it.d = d; it.i = i; it.tag = tag;
        q.push_back(it);
        sample_req = 1'b1;
        @(negedge clk); #1;
        sample_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3); #1;
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd6, 32'h0, 1'b0, "R1 status");
        rd(4'd7, 32'h0, 1'b0, "R1 enable");
        rd(4'd8, 32'h0, 1'b0, "R1 control");
        rd(4'd9, 32'h0, 1'b0, "R1 counter");
        rd(4'd10, 32'h0, 1'b0, "R1 load");
        rd(4'd13, 32'h0, 1'b0, "R1 match");
        rd(4'd14, 32'h0, 1'b0, "R1 capture");
        // R2 identification and unmapped offset
        rd(4'd0, 32'h10, 1'b0, "R2 id");
        wr(4'd0, 32'hFF);
        rd(4'd0, 32'h10, 1'b0, "R2 id write ignored");
        rd(4'd3, 32'h0, 1'b0, "R2 unmapped");

        // R3 live count, start and stop
        wr(4'd9, 32'h80);
        wr(4'd8, 32'h1);
        rd(4'd9, 32'h81, 1'b0, "R3 first step");
        wr(4'd8, 32'h0);
        rd(4'd9, 32'h83, 1'b0, "R3 stop value");
        rd(4'd9, 32'h83, 1'b0, "R3 frozen");
        rd(4'd8, 32'h0, 1'b0, "R3 control readback");

        // R4 overflow reload
        wr(4'd7, 32'h2);
        wr(4'd10, 32'h100);
        wr(4'd9, 32'hFFFF_FFFD);
        wr(4'd8, 32'h1);
        rd(4'd9, 32'hFFFF_FFFE, 1'b0, "R4 before top");
        rd(4'd9, 32'hFFFF_FFFF, 1'b0, "R4 at top");
        rd(4'd9, 32'h100, 1'b1, "R4 reloaded");
        rd(4'd6, 32'h2, 1'b1, "R4 overflow flag");
        wr(4'd8, 32'h0);

        // R9 enable gating, R7 write-one-to-clear
        wr(4'd7, 32'h0);
        rd(4'd6, 32'h2, 1'b0, "R9 masked");
        wr(4'd7, 32'h2);
        rd(4'd6, 32'h2, 1'b1, "R9 enabled");
        wr(4'd6, 32'h0);
        rd(4'd6, 32'h2, 1'b1, "R7 zero write keeps");
        wr(4'd6, 32'h5);
        rd(4'd6, 32'h2, 1'b1, "R7 other bits keep");
        wr(4'd6, 32'h2);
        rd(4'd6, 32'h0, 1'b0, "R7 cleared");

        // R5 match fires on increment
        wr(4'd7, 32'h1);
        wr(4'd9, 32'h50);
        wr(4'd13, 32'h53);
        wr(4'd8, 32'h41);
        rd(4'd8, 32'h41, 1'b0, "R5 control readback");
        rd(4'd9, 32'h52, 1'b0, "R5 approaching");
        rd(4'd6, 32'h1, 1'b1, "R5 match flag");
        wr(4'd6, 32'h1);
        rd(4'd6, 32'h0, 1'b0, "R5 no refire");
        wr(4'd8, 32'h0);

        // R5 no fire when counter starts at match value
        wr(4'd13, 32'h60);
        wr(4'd9, 32'h60);
        wr(4'd8, 32'h41);
        rd(4'd9, 32'h61, 1'b0, "R5 left equal value");
        rd(4'd6, 32'h0, 1'b0, "R5 equal start no fire");
        wr(4'd8, 32'h40);
        wr(4'd9, 32'h60);
        idle(3);
        rd(4'd6, 32'h0, 1'b0, "R5 frozen or written no fire");
        wr(4'd13, 32'h81);
        wr(4'd9, 32'h80);
        wr(4'd8, 32'h1);
        rd(4'd9, 32'h81, 1'b0, "R5 match disabled count");
        rd(4'd6, 32'h0, 1'b0, "R5 match disabled no fire");
        wr(4'd8, 32'h0);

        // R8 event wins over simultaneous clear
        wr(4'd9, 32'h50);
        wr(4'd13, 32'h52);
        wr(4'd8, 32'h41);
        wr(4'd6, 32'h1);
        rd(4'd6, 32'h1, 1'b1, "R8 event beats clear");
        wr(4'd8, 32'h0);
        wr(4'd6, 32'h7);

        // R6 capture
        wr(4'd7, 32'h4);
        wr(4'd9, 32'h1234);
        cap_in = 1'b1;
        idle(5);
        rd(4'd14, 32'h1234, 1'b1, "R6 captured");
        rd(4'd6, 32'h4, 1'b1, "R6 capture flag");
        wr(4'd6, 32'h4);
        wr(4'd9, 32'h5678);
        idle(5);
        rd(4'd14, 32'h1234, 1'b0, "R6 held high no recapture");
        rd(4'd6, 32'h0, 1'b0, "R6 held high no flag");
        cap_in = 1'b0;
        idle(5);
        cap_in = 1'b1;
        idle(5);
        rd(4'd14, 32'h5678, 1'b1, "R6 second edge");
        rd(4'd6, 32'h4, 1'b1, "R6 second flag");

        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule